// File: doc/BRIEF.md
# Electronic Shutter Sweep Scheduler

This block sits in a CCD camera timing path and decides, line by line, whether the substrate discharge pulse fires. A field-start strobe begins a field and a line-start strobe (HD) marks every following line. While the pulse keeps firing, the charge built up in the sensor is swept away. Exposure starts on the first line after the one picked by a 9-bit shutter code. The code and both mode selects are captured once per field, so any change in the middle of a field takes effect only at the next field start.

The valid range of the code depends on the video standard. Code values up to the last valid one request a sweep. The value just above that range is prohibited: it is handled as shutter off and raises an error flag. Every higher value turns the shutter off. The position of the pulse inside the line depends on the component/composite select. The pulse runs active low for a fixed number of clocks.

Top module: `shutter_sweep_sched`

## Requirements
- R1: `shutter_code_i`, `std_ccir_i` and `composite_i` are sampled only on the clock edge where `field_start_i` is high. A change at any other time has no effect before the next field start.
- R2: The line index is set to 0 on a field-start edge; field start wins over a coincident HD. Each other HD edge adds one. The index saturates at 511 and never wraps back to low lines.
- R3: With a sweep code (0..261 when `std_ccir_i`=0, 0..311 when `std_ccir_i`=1), one XSUB pulse is issued on every line from 0 up to and including the code. No pulse is issued on any later line of the field.
- R4: The prohibited code (262 when `std_ccir_i`=0, 312 when `std_ccir_i`=1) produces no XSUB pulse in that field and holds `code_err_o` high for the whole field.
- R5: Codes above the prohibited value, up to 511, produce no XSUB pulse and leave `code_err_o` low.
- R6: Count the edge that samples the line-start strobe as edge 0. `xsub_n_o` is low after edges OFS through OFS+15, which is exactly 16 clocks. OFS is 20 when `composite_i`=0 was latched and 18 when `composite_i`=1 was latched. A new line start restarts this timing.
- R7: `expose_o` is high after the first field start when the latched code is off or prohibited, or when the current line index is above a sweep code. It is low otherwise, so it is never high while an XSUB pulse is low.
- R8: `code_err_o` is low for sweep and off codes and is low before the first field start.
- R9: While `rst_ni` is low and after reset, `xsub_n_o`=1, `expose_o`=0 and `code_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | One-clock line-start strobe |
| field_start_i | input | 1 | One-clock strobe that starts a field; it also starts line 0 |
| std_ccir_i | input | 1 | Standard select: 0 = 525-line, 1 = 625-line |
| composite_i | input | 1 | 0 = component clocking, 1 = composite clocking (selects the pulse offset) |
| shutter_code_i | input | 9 | Shutter code, captured at field start |
| xsub_n_o | output | 1 | Substrate discharge pulse, active low |
| expose_o | output | 1 | High while charge is accumulating |
| code_err_o | output | 1 | High for a field whose latched code is prohibited |

## Verification
The bench goes after the range edges in both standards: codes 261, 262 and 263 on one side, 311, 312 and 313 on the other. A design with an off-by-one limit would sweep one line too few or too many, or would let the prohibited code sweep. A run of 600 lines with code 311 tests saturation, because a counter that wraps would resume pulsing after line 511. Field starts that coincide with HD, line lengths shorter than the pulse window, and random input changes in the middle of a field check the priority, the restart and the per-field capture. If any of these is wrong, pulses show up on the wrong lines or the flags change in the middle of a field.

// File: rtl/shsw_pkg.sv
package shsw_pkg;
   typedef enum logic [1:0] {
      CODE_SWEEP = 2'd0,
      CODE_OFF   = 2'd1,
      CODE_BAD   = 2'd2
   } code_class_e;
endpackage

// File: rtl/shsw_classify.sv
module shsw_classify
   import shsw_pkg::*;
#(
   parameter int CODE_W    = 9,
   parameter int EIA_LAST  = 261,
   parameter int CCIR_LAST = 311
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              std_ccir_i,
   output code_class_e       class_o
);
   logic [1:0] is_sweep;
   logic [1:0] is_bad;

   // one range decoder per standard; the select picks the active one
   for (genvar gs = 0; gs < 2; gs++) begin : g_std
      localparam int LAST = (gs == 0) ? EIA_LAST : CCIR_LAST;
      localparam logic [CODE_W-1:0] LAST_C = CODE_W'(LAST);
      localparam logic [CODE_W-1:0] BAD_C  = CODE_W'(LAST + 1);
      assign is_sweep[gs] = (code_i <= LAST_C);
      assign is_bad[gs]   = (code_i == BAD_C);
   end

   always_comb begin
      if (is_sweep[std_ccir_i])    class_o = CODE_SWEEP;
      else if (is_bad[std_ccir_i]) class_o = CODE_BAD;
      else                         class_o = CODE_OFF;
   end
endmodule

// File: rtl/shsw_line_ctr.sv
module shsw_line_ctr #(
   parameter int LINE_W = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              field_start_i,
   input  logic              hd_i,
   output logic [LINE_W-1:0] line_q,
   output logic [LINE_W-1:0] line_nxt
);
   localparam logic [LINE_W-1:0] LINE_MAX = '1;

   always_comb begin
      if (field_start_i)        line_nxt = '0;
      else if (!hd_i)           line_nxt = line_q;
      else if (line_q == LINE_MAX) line_nxt = LINE_MAX;
      else                      line_nxt = line_q + LINE_W'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) line_q <= '0;
      else         line_q <= line_nxt;
   end
endmodule

// File: rtl/shsw_pulse_timer.sv
module shsw_pulse_timer #(
   parameter int PULSE_W  = 16,
   parameter int OFS_COMP = 20,
   parameter int OFS_CPST = 18
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic arm_i,
   input  logic composite_i,
   output logic pulse_n_o
);
   localparam int OFS_MAX = (OFS_COMP > OFS_CPST) ? OFS_COMP : OFS_CPST;
   localparam int POS_TOP = OFS_MAX + PULSE_W;
   localparam int POS_W   = $clog2(POS_TOP + 1);
   localparam logic [POS_W-1:0] POS_MAX = POS_W'(POS_TOP);

   logic [POS_W-1:0] pos_q;
   logic             armed_q;
   logic [POS_W-1:0] win_lo;
   logic [POS_W-1:0] win_hi;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q   <= POS_MAX;
         armed_q <= 1'b0;
      end else if (restart_i) begin
         pos_q   <= '0;
         armed_q <= arm_i;
      end else if (pos_q != POS_MAX) begin
         pos_q   <= pos_q + POS_W'(1);
      end
   end

   assign win_lo    = composite_i ? POS_W'(OFS_CPST) : POS_W'(OFS_COMP);
   assign win_hi    = composite_i ? POS_W'(OFS_CPST + PULSE_W) : POS_W'(OFS_COMP + PULSE_W);
   assign pulse_n_o = !(armed_q && (pos_q >= win_lo) && (pos_q < win_hi));
endmodule

// File: rtl/shutter_sweep_sched.sv
module shutter_sweep_sched
   import shsw_pkg::*;
#(
   parameter int CODE_W    = 9,
   parameter int LINE_W    = 9,
   parameter int EIA_LAST  = 261,
   parameter int CCIR_LAST = 311,
   parameter int PULSE_W   = 16,
   parameter int OFS_COMP  = 20,
   parameter int OFS_CPST  = 18
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hd_i,
   input  logic              field_start_i,
   input  logic              std_ccir_i,
   input  logic              composite_i,
   input  logic [CODE_W-1:0] shutter_code_i,
   output logic              xsub_n_o,
   output logic              expose_o,
   output logic              code_err_o
);
   if (LINE_W < CODE_W) begin : g_chk_line
      $error("LINE_W must cover the code range");
   end
   if (CCIR_LAST + 1 >= (1 << CODE_W) || EIA_LAST + 1 >= (1 << CODE_W)) begin : g_chk_code
      $error("prohibited code must fit in CODE_W bits");
   end
   if (PULSE_W < 1 || OFS_COMP < 1 || OFS_CPST < 1) begin : g_chk_pulse
      $error("pulse width and offsets must be positive");
   end

   code_class_e       class_now;
   code_class_e       class_q;
   logic [CODE_W-1:0] code_q;
   logic              cpst_q;
   logic              seen_q;
   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] line_nxt;
   logic              arm_nxt;
   logic              line_start;

   shsw_classify #(
      .CODE_W   (CODE_W),
      .EIA_LAST (EIA_LAST),
      .CCIR_LAST(CCIR_LAST)
   ) u_classify (
      .code_i    (shutter_code_i),
      .std_ccir_i(std_ccir_i),
      .class_o   (class_now)
   );

   shsw_line_ctr #(.LINE_W(LINE_W)) u_line (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .field_start_i(field_start_i),
      .hd_i         (hd_i),
      .line_q       (line_q),
      .line_nxt     (line_nxt)
   );

   // per-field capture of code, mode and code class
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         class_q <= CODE_OFF;
         code_q  <= '0;
         cpst_q  <= 1'b0;
         seen_q  <= 1'b0;
      end else if (field_start_i) begin
         class_q <= class_now;
         code_q  <= shutter_code_i;
         cpst_q  <= composite_i;
         seen_q  <= 1'b1;
      end
   end

   assign line_start = field_start_i | hd_i;
   // line 0 of a sweep field always pulses; later lines pulse up to the code
   assign arm_nxt = field_start_i ? (class_now == CODE_SWEEP)
                                  : ((class_q == CODE_SWEEP) &&
                                     (line_nxt <= LINE_W'(code_q)));

   shsw_pulse_timer #(
      .PULSE_W (PULSE_W),
      .OFS_COMP(OFS_COMP),
      .OFS_CPST(OFS_CPST)
   ) u_pulse (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .restart_i  (line_start),
      .arm_i      (arm_nxt),
      .composite_i(cpst_q),
      .pulse_n_o  (xsub_n_o)
   );

   assign expose_o   = seen_q && ((class_q != CODE_SWEEP) || (line_q > LINE_W'(code_q)));
   assign code_err_o = seen_q && (class_q == CODE_BAD);
endmodule

// File: rtl/shutter_sweep_sched_chk.sv
module shutter_sweep_sched_chk #(
   parameter int LINE_W = 9
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              hd_i,
   input logic              field_start_i,
   input logic              xsub_n_o,
   input logic              expose_o,
   input logic              code_err_o,
   input logic [LINE_W-1:0] line_q
);
   localparam logic [LINE_W-1:0] LMAX = '1;

   assert_sweep_not_exposing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !xsub_n_o |-> !expose_o);
   assert_exposure_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expose_o && !field_start_i |=> expose_o);
   assert_bad_code_silent_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_err_o |-> xsub_n_o);
   assert_bad_code_exposes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_err_o |-> expose_o);
   assert_err_per_field_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !field_start_i |=> $stable(code_err_o));
   assert_line_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      field_start_i |=> (line_q == '0));
   assert_line_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hd_i && !field_start_i && (line_q != LMAX) |=> (line_q == $past(line_q) + LINE_W'(1)));
   assert_line_sat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hd_i && !field_start_i && (line_q == LMAX) |=> (line_q == LMAX));
endmodule

bind shutter_sweep_sched shutter_sweep_sched_chk #(.LINE_W(LINE_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .hd_i         (hd_i),
   .field_start_i(field_start_i),
   .xsub_n_o     (xsub_n_o),
   .expose_o     (expose_o),
   .code_err_o   (code_err_o),
   .line_q       (line_q)
);

// File: tb/test_shutter_sweep_sched.sv
module test_shutter_sweep_sched;
   localparam int CLK_PERIOD = 10;
   localparam int WIN_W = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hd = 1'b0;
   logic       fs = 1'b0;
   logic       std_c = 1'b0;
   logic       cpst = 1'b0;
   logic [8:0] code = '0;
   logic       xsub_n, expose, err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // model state, taken from the requirements
   bit  m_seen = 0, m_armed = 0, m_cpst = 0;
   int  m_class = 1;   // 0 sweep, 1 off, 2 prohibited
   int  m_code = 0, m_line = 0, m_pos = 63;
   string ctx = "reset";

   always #(CLK_PERIOD/2) clk = ~clk;

   shutter_sweep_sched i_shutter_sweep_sched (
      .clk_i(clk), .rst_ni(rst_n), .hd_i(hd), .field_start_i(fs),
      .std_ccir_i(std_c), .composite_i(cpst), .shutter_code_i(code),
      .xsub_n_o(xsub_n), .expose_o(expose), .code_err_o(err));

   function automatic int classify(int c, bit s);
      int last = s ? 311 : 261;
      if (c <= last) return 0;
      if (c == last + 1) return 2;
      return 1;
   endfunction

   function automatic bit exp_xsub();
      int ofs = m_cpst ? 18 : 20;   // R6
      return !(m_armed && m_pos >= ofs && m_pos < ofs + WIN_W);
   endfunction

   task automatic check(string what, string req, bit act, bit expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s (%s) line=%0d actual=%0b expected=%0b",
                  req, what, ctx, m_line, act, expv);
      end
   endtask

   task automatic compare_all();
      check("xsub_n", "R3 R5 R6", xsub_n, exp_xsub());
      check("expose", "R7", expose, m_seen && (m_class != 0 || m_line > m_code));
      check("code_err", "R4 R8", err, m_seen && m_class == 2);
   endtask

   // one clock: compare, drive, advance model to the post-edge state
   task automatic step(bit f, bit h, int c, bit s, bit m);
      @(negedge clk);
      compare_all();
      fs = f; hd = h; code = 9'(c); std_c = s; cpst = m;
      if (f) begin
         m_seen = 1; m_class = classify(c, s); m_code = c; m_cpst = m;
         m_line = 0; m_pos = 0; m_armed = (m_class == 0);
      end else if (h) begin
         m_line = (m_line == 511) ? 511 : m_line + 1;   // R2
         m_pos = 0; m_armed = (m_class == 0) && (m_line <= m_code);
      end else if (m_pos < 63) begin
         m_pos++;
      end
   endtask

   task automatic run_field(bit s, bit m, int c, int nlines, int llen, bit coincide, bit chaos);
      for (int ln = 0; ln < nlines; ln++) begin
         for (int k = 0; k < llen; k++) begin
            bit f = (ln == 0 && k == 0);
            bit h = (k == 0) && (ln != 0 || coincide);
            if (f || !chaos) step(f, h, c, s, m);
            else step(f, h, int'($urandom % 512), 1'($urandom), 1'($urandom));
         end
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_up();
   end

   initial begin
      void'($urandom(32'h5eed));
      // R9: outputs during reset
      repeat (3) begin
         @(negedge clk);
         check("xsub_n", "R9", xsub_n, 1'b1);
         check("expose", "R9", expose, 1'b0);
         check("code_err", "R9", err, 1'b0);
      end
      @(negedge clk); rst_n = 1'b1;
      ctx = "idle R8 R9";
      repeat (4) step(0, 1, 0, 0, 0);   // HD before any field: no pulse, flags low

      ctx = "eia code0 R3";         run_field(0, 0, 0, 4, 40, 0, 0);
      ctx = "eia composite R6 R2";  run_field(0, 1, 5, 8, 40, 1, 0);
      ctx = "eia prohibited R4";    run_field(0, 0, 262, 4, 40, 0, 0);
      ctx = "eia off R5";           run_field(0, 0, 263, 3, 40, 0, 0);
      ctx = "eia max off R5";       run_field(0, 1, 511, 3, 40, 0, 0);
      ctx = "ccir prohibited R4";   run_field(1, 0, 312, 4, 40, 1, 0);
      ctx = "ccir off R5";          run_field(1, 1, 313, 3, 40, 0, 0);
      ctx = "ccir 262 sweep R3";    run_field(1, 0, 262, 5, 40, 0, 0);
      ctx = "short lines R6";       run_field(0, 0, 6, 9, 25, 0, 0);
      ctx = "mid-field changes R1"; run_field(1, 1, 3, 7, 40, 0, 1);
      ctx = "eia last R3";          run_field(0, 0, 261, 264, 36, 0, 0);
      ctx = "ccir saturation R2";   run_field(1, 0, 311, 600, 36, 1, 0);

      for (int n = 0; n < 30; n++) begin
         bit s = 1'($urandom);
         int last = s ? 311 : 261;
         int sel = int'($urandom % 6);
         int c, nl;
         if (sel < 3)       begin c = int'($urandom % 20); nl = c + 3; end
         else if (sel == 3) begin c = last + 1; nl = 4; end
         else if (sel == 4) begin c = last + 2 + int'($urandom % (510 - last)); nl = 4; end
         else               begin c = last - int'($urandom % 3); nl = 6; end
         ctx = "random R1 R3";
         run_field(s, 1'($urandom), c, nl, 20 + int'($urandom % 41),
                   1'($urandom), 1'($urandom));
      end
      step(0, 0, 0, 0, 0);
      finish_up();
   end
endmodule